// File: doc/BRIEF.md
# Headset Orientation Detection Controller

This block works out how an analog headset plugged into a USB Type-C receptacle is wired. It then routes the analog switches to match. A 4-pole headset can put its microphone on either sideband wire, with audio ground on the other one. A 3-pole headset has no microphone at all. Outside logic measures two cross resistances and hands them in with a valid strobe: the first with current driven from SBU1 to SBU2, the second the reverse. The block compares both values against a low threshold and a high threshold. From that it picks the jack type and the routing of microphone, audio ground and the ground-sense path.

Software arms detection by setting an enable bit. Detection starts only once the left, right and audio-ground switch enables are all on. From that point until the decision is made, every audio switch is held open. After the decision, left and right close at once. Microphone, sense and ground then close after their own programmable tick delays. The enable bit then clears itself and a completion flag is raised, which drives an active-low interrupt unless it is masked.

Top module: `hs_orient_det`

## Requirements
- R1: Detection starts only when the enable bit is set and the left, right and audio-ground switch enables (`l_sw_en`, `r_sw_en`, `gnd_sw_en`) are all 1. Otherwise the switch outputs keep following their enables and the enable bit stays set.
- R2: From the start of detection until the decision is taken, `sw_l_on`, `sw_r_on`, `sw_mic_on`, `sw_sense_on` and `sw_gnd_on` are all 0.
- R3: `det_en_q` is set by a `det_arm` pulse and returns to 0 by itself when detection and configuration complete.
- R4: After reset the low threshold is 0x20, the high threshold is 0xFF and `jack_status` is 4'b0001. `det_en_q`, `done_flag` and all route selects are 0, and `irq_n` is 1.
- R5: If the low threshold is greater than or equal to both measurements, the jack is 3-pole. `jack_status` becomes 4'b0010, ground goes to SBU1 (`gnd_on_sbu2`=0), sense goes to GSBU1 (`sense_on_gsbu2`=0), `mic_on_sbu1`=0, and `sw_mic_on` stays 0 until a later detection selects a 4-pole route.
- R6: If the first measurement exceeds the second, the second is below the high threshold and the first exceeds the low threshold, the microphone goes to SBU1. In that case `mic_on_sbu1`=1, `gnd_on_sbu2`=1, `sense_on_gsbu2`=1 and `jack_status`=4'b0100.
- R7: The mirrored condition (second above first, first below high threshold, second above low threshold) routes the microphone to SBU2. It gives `mic_on_sbu1`=0, `gnd_on_sbu2`=0, `sense_on_gsbu2`=0 and `jack_status`=4'b1000.
- R8: If both measurements are at or above the high threshold, and R5 does not apply, the routing and `jack_status` keep their previous values.
- R9: Any combination that none of R5 to R8 covers keeps the previous routing and status. Completion is still reported.
- R10: `jack_status` always has exactly one bit set: bit 3 for microphone on SBU2, bit 2 for microphone on SBU1, bit 1 for 3-pole, bit 0 for no accessory.
- R11: On completion `done_flag` goes to 1. An `irq_clr` pulse clears it. `irq_n` is low while `done_flag` is 1 and `irq_mask` is 0, and is high otherwise.
- R12: After the decision, `sw_l_on` and `sw_r_on` follow their enables at once. `sw_mic_on`, `sw_sense_on` and `sw_gnd_on` close `mic_dly`, `sense_dly` and `gnd_dly` cycles after the left/right release. A delay of 0 closes the switch in the same cycle as left/right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_arm | input | 1 | Pulse that sets the detection enable bit |
| l_sw_en | input | 1 | Left audio switch enable |
| r_sw_en | input | 1 | Right audio switch enable |
| gnd_sw_en | input | 1 | Audio-ground switch enable |
| mic_sw_en | input | 1 | Microphone switch enable |
| sense_sw_en | input | 1 | Ground-sense switch enable |
| thr_lo_wr | input | 1 | Write strobe for the low threshold |
| thr_hi_wr | input | 1 | Write strobe for the high threshold |
| thr_wdata | input | 8 | Threshold write data |
| meas_vld | input | 1 | Measurement pair valid strobe |
| meas_12 | input | 8 | Resistance code, SBU1 to SBU2 |
| meas_21 | input | 8 | Resistance code, SBU2 to SBU1 |
| mic_dly | input | DLY_W | Microphone release delay in cycles |
| sense_dly | input | DLY_W | Sense release delay in cycles |
| gnd_dly | input | DLY_W | Ground release delay in cycles |
| irq_mask | input | 1 | Masks the interrupt output |
| irq_clr | input | 1 | Read-clear pulse for the completion flag |
| det_en_q | output | 1 | Detection enable bit |
| sw_l_on | output | 1 | Left switch closed |
| sw_r_on | output | 1 | Right switch closed |
| sw_mic_on | output | 1 | Microphone switch closed |
| sw_sense_on | output | 1 | Sense switch closed |
| sw_gnd_on | output | 1 | Audio-ground switch closed |
| mic_on_sbu1 | output | 1 | 1: microphone on SBU1, 0: on SBU2 |
| gnd_on_sbu2 | output | 1 | 1: audio ground on SBU2, 0: on SBU1 |
| sense_on_gsbu2 | output | 1 | 1: sense to GSBU2, 0: to GSBU1 |
| jack_status | output | 4 | One-hot jack type |
| done_flag | output | 1 | Completion flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check the following on every cycle:
- all five switches stay open during the decision window;
- entry into detection follows the start condition;
- the enable bit drops and the flag rises exactly as the sequence ends;
- `jack_status` stays one-hot;
- the 3-pole and SBU1-microphone routes stay consistent with the reported status;
- the mask keeps the interrupt high.

Some behaviour only the bench scenarios can show:
- that a given pair of measurements and thresholds leads to the right class, which the bench covers by sweeping a grid of values over two threshold settings;
- that the hold cases really keep the earlier route;
- the exact cycle at which each delayed switch closes.

// File: rtl/hs_orient_pkg.sv
package hs_orient_pkg;

  localparam int MEAS_W = 8;
  typedef logic [MEAS_W-1:0] meas_t;

  localparam meas_t THR_LO_RST = 8'h20;
  localparam meas_t THR_HI_RST = 8'hFF;
  localparam meas_t MEAS_RST   = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT    = 2'd1,
    ST_DECIDE  = 2'd2,
    ST_RELEASE = 2'd3
  } hod_state_e;

  typedef enum logic [1:0] {
    CLS_HOLD     = 2'd0,
    CLS_THREE    = 2'd1,
    CLS_MIC_SBU1 = 2'd2,
    CLS_MIC_SBU2 = 2'd3
  } hod_cls_e;

  localparam logic [3:0] JS_NONE  = 4'b0001;
  localparam logic [3:0] JS_THREE = 4'b0010;
  localparam logic [3:0] JS_MIC1  = 4'b0100;
  localparam logic [3:0] JS_MIC2  = 4'b1000;

  // Decision rules in priority order; the first match wins.
  function automatic hod_cls_e classify(input meas_t r12, input meas_t r21,
                                        input meas_t lo, input meas_t hi);
    logic below_lo;
    logic above_hi;
    logic side1;
    logic side2;
    below_lo = (r12 <= lo) && (r21 <= lo);
    above_hi = (r12 >= hi) && (r21 >= hi);
    side1    = (r12 > r21) && (r21 < hi) && (r12 > lo);
    side2    = (r21 > r12) && (r12 < hi) && (r21 > lo);
    if (below_lo)      classify = CLS_THREE;
    else if (above_hi) classify = CLS_HOLD;
    else if (side1)    classify = CLS_MIC_SBU1;
    else if (side2)    classify = CLS_MIC_SBU2;
    else               classify = CLS_HOLD;
  endfunction

endpackage

// File: rtl/hs_orient_regs.sv
module hs_orient_regs
  import hs_orient_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  thr_lo_wr,
  input  logic  thr_hi_wr,
  input  meas_t thr_wdata,
  input  logic  meas_vld,
  input  meas_t meas_12,
  input  meas_t meas_21,
  output meas_t thr_lo_q,
  output meas_t thr_hi_q,
  output meas_t m12_q,
  output meas_t m21_q
);

  localparam int N_THR = 2;
  localparam int N_MEAS = 2;

  meas_t thr_rst [N_THR];
  meas_t thr_q   [N_THR];
  logic  thr_we  [N_THR];
  meas_t m_in    [N_MEAS];
  meas_t m_q     [N_MEAS];

  assign thr_rst[0] = THR_LO_RST;
  assign thr_rst[1] = THR_HI_RST;
  assign thr_we[0]  = thr_lo_wr;
  assign thr_we[1]  = thr_hi_wr;
  assign m_in[0]    = meas_12;
  assign m_in[1]    = meas_21;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         thr_q[t] <= (t == 0) ? THR_LO_RST : THR_HI_RST;
      else if (thr_we[t]) thr_q[t] <= thr_wdata;
    end
  end

  for (genvar m = 0; m < N_MEAS; m++) begin : g_meas
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        m_q[m] <= MEAS_RST;
      else if (meas_vld) m_q[m] <= m_in[m];
    end
  end

  assign thr_lo_q = thr_q[0];
  assign thr_hi_q = thr_q[1];
  assign m12_q    = m_q[0];
  assign m21_q    = m_q[1];

  meas_t unused_rst_view;
  assign unused_rst_view = thr_rst[0] ^ thr_rst[1];

endmodule

// File: rtl/hs_orient_cls.sv
module hs_orient_cls
  import hs_orient_pkg::*;
(
  input  meas_t    m12,
  input  meas_t    m21,
  input  meas_t    thr_lo,
  input  meas_t    thr_hi,
  output hod_cls_e cls
);

  assign cls = classify(m12, m21, thr_lo, thr_hi);

endmodule

// File: rtl/hs_orient_seq.sv
module hs_orient_seq #(
  parameter int DLY_W = 8,
  parameter int N_STG = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic [N_STG*DLY_W-1:0] dly_flat,
  output logic [N_STG-1:0]       stg_go,
  output logic                   last
);

  logic [DLY_W-1:0] cnt_q;

  for (genvar s = 0; s < N_STG; s++) begin : g_stg
    assign stg_go[s] = run && (cnt_q >= dly_flat[s*DLY_W +: DLY_W]);
  end

  assign last = run && (&stg_go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (!last) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/hs_orient_det.sv
module hs_orient_det
  import hs_orient_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_arm,
  input  logic             l_sw_en,
  input  logic             r_sw_en,
  input  logic             gnd_sw_en,
  input  logic             mic_sw_en,
  input  logic             sense_sw_en,
  input  logic             thr_lo_wr,
  input  logic             thr_hi_wr,
  input  logic [7:0]       thr_wdata,
  input  logic             meas_vld,
  input  logic [7:0]       meas_12,
  input  logic [7:0]       meas_21,
  input  logic [DLY_W-1:0] mic_dly,
  input  logic [DLY_W-1:0] sense_dly,
  input  logic [DLY_W-1:0] gnd_dly,
  input  logic             irq_mask,
  input  logic             irq_clr,
  output logic             det_en_q,
  output logic             sw_l_on,
  output logic             sw_r_on,
  output logic             sw_mic_on,
  output logic             sw_sense_on,
  output logic             sw_gnd_on,
  output logic             mic_on_sbu1,
  output logic             gnd_on_sbu2,
  output logic             sense_on_gsbu2,
  output logic [3:0]       jack_status,
  output logic             done_flag,
  output logic             irq_n
);

  localparam int N_STG   = 3;
  localparam int STG_MIC = 0;
  localparam int STG_SNS = 1;
  localparam int STG_GND = 2;

  hod_state_e state_q, state_d;
  meas_t      thr_lo_q, thr_hi_q, m12_q, m21_q;
  hod_cls_e   cls;
  logic [N_STG-1:0] stg_go;
  logic       seq_last;

  // Named internal events, observed by the checker.
  logic start_ok;
  logic hold_off;
  logic busy;
  logic rel_run;
  logic finish;
  logic decide;

  logic three_q;

  hs_orient_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_lo_wr (thr_lo_wr),
    .thr_hi_wr (thr_hi_wr),
    .thr_wdata (thr_wdata),
    .meas_vld  (meas_vld),
    .meas_12   (meas_12),
    .meas_21   (meas_21),
    .thr_lo_q  (thr_lo_q),
    .thr_hi_q  (thr_hi_q),
    .m12_q     (m12_q),
    .m21_q     (m21_q)
  );

  hs_orient_cls u_cls (
    .m12    (m12_q),
    .m21    (m21_q),
    .thr_lo (thr_lo_q),
    .thr_hi (thr_hi_q),
    .cls    (cls)
  );

  hs_orient_seq #(.DLY_W(DLY_W), .N_STG(N_STG)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (rel_run),
    .dly_flat ({gnd_dly, sense_dly, mic_dly}),
    .stg_go   (stg_go),
    .last     (seq_last)
  );

  assign start_ok = det_en_q && l_sw_en && r_sw_en && gnd_sw_en;
  assign hold_off = (state_q == ST_WAIT) || (state_q == ST_DECIDE);
  assign busy     = (state_q != ST_IDLE);
  assign rel_run  = (state_q == ST_RELEASE);
  assign decide   = (state_q == ST_DECIDE);
  assign finish   = rel_run && seq_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_ok) state_d = ST_WAIT;
      ST_WAIT:    if (meas_vld) state_d = ST_DECIDE;
      ST_DECIDE:  state_d = ST_RELEASE;
      ST_RELEASE: if (seq_last) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       det_en_q <= 1'b0;
    else if (finish)  det_en_q <= 1'b0;
    else if (det_arm) det_en_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      three_q        <= 1'b0;
      mic_on_sbu1    <= 1'b0;
      gnd_on_sbu2    <= 1'b0;
      sense_on_gsbu2 <= 1'b0;
      jack_status    <= JS_NONE;
    end else if (decide) begin
      unique case (cls)
        CLS_THREE: begin
          three_q        <= 1'b1;
          mic_on_sbu1    <= 1'b0;
          gnd_on_sbu2    <= 1'b0;
          sense_on_gsbu2 <= 1'b0;
          jack_status    <= JS_THREE;
        end
        CLS_MIC_SBU1: begin
          three_q        <= 1'b0;
          mic_on_sbu1    <= 1'b1;
          gnd_on_sbu2    <= 1'b1;
          sense_on_gsbu2 <= 1'b1;
          jack_status    <= JS_MIC1;
        end
        CLS_MIC_SBU2: begin
          three_q        <= 1'b0;
          mic_on_sbu1    <= 1'b0;
          gnd_on_sbu2    <= 1'b0;
          sense_on_gsbu2 <= 1'b0;
          jack_status    <= JS_MIC2;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_flag <= 1'b0;
    else if (finish)  done_flag <= 1'b1;
    else if (irq_clr) done_flag <= 1'b0;
  end

  assign irq_n = !(done_flag && !irq_mask);

  assign sw_l_on     = !hold_off && l_sw_en;
  assign sw_r_on     = !hold_off && r_sw_en;
  assign sw_mic_on   = !hold_off && mic_sw_en && !three_q && (!rel_run || stg_go[STG_MIC]);
  assign sw_sense_on = !hold_off && sense_sw_en && (!rel_run || stg_go[STG_SNS]);
  assign sw_gnd_on   = !hold_off && gnd_sw_en && (!rel_run || stg_go[STG_GND]);

endmodule

// File: rtl/hs_orient_chk.sv
module hs_orient_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_off,
  input logic       busy,
  input logic       start_ok,
  input logic       det_en_q,
  input logic       sw_l_on,
  input logic       sw_r_on,
  input logic       sw_mic_on,
  input logic       sw_sense_on,
  input logic       sw_gnd_on,
  input logic       mic_on_sbu1,
  input logic       gnd_on_sbu2,
  input logic       sense_on_gsbu2,
  input logic [3:0] jack_status,
  input logic       done_flag,
  input logic       irq_mask,
  input logic       irq_n
);

  AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_ok)); // R1

  AST_HOLD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    hold_off |-> !(sw_l_on || sw_r_on || sw_mic_on || sw_sense_on || sw_gnd_on)); // R2

  AST_EN_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !det_en_q); // R3

  AST_THREE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (jack_status == 4'b0010) |-> (!sw_mic_on && !gnd_on_sbu2 && !sense_on_gsbu2)); // R5

  AST_MIC1_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (jack_status == 4'b0100) |-> (mic_on_sbu1 && gnd_on_sbu2 && sense_on_gsbu2)); // R6

  AST_STATUS_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(jack_status) == 1); // R10

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag); // R11

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> irq_n); // R11

endmodule

bind hs_orient_det hs_orient_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .hold_off       (hold_off),
  .busy           (busy),
  .start_ok       (start_ok),
  .det_en_q       (det_en_q),
  .sw_l_on        (sw_l_on),
  .sw_r_on        (sw_r_on),
  .sw_mic_on      (sw_mic_on),
  .sw_sense_on    (sw_sense_on),
  .sw_gnd_on      (sw_gnd_on),
  .mic_on_sbu1    (mic_on_sbu1),
  .gnd_on_sbu2    (gnd_on_sbu2),
  .sense_on_gsbu2 (sense_on_gsbu2),
  .jack_status    (jack_status),
  .done_flag      (done_flag),
  .irq_mask       (irq_mask),
  .irq_n          (irq_n)
);

// File: tb/hs_orient_det_tb.sv
module hs_orient_det_tb_top;

  localparam int DLY_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_arm = 0, l_sw_en = 1, r_sw_en = 1, gnd_sw_en = 1, mic_sw_en = 1, sense_sw_en = 1;
  logic thr_lo_wr = 0, thr_hi_wr = 0;
  logic [7:0] thr_wdata = 0;
  logic meas_vld = 0;
  logic [7:0] meas_12 = 0, meas_21 = 0;
  logic [DLY_W-1:0] mic_dly = 0, sense_dly = 0, gnd_dly = 0;
  logic irq_mask = 0, irq_clr = 0;
  logic det_en_q, sw_l_on, sw_r_on, sw_mic_on, sw_sense_on, sw_gnd_on;
  logic mic_on_sbu1, gnd_on_sbu2, sense_on_gsbu2, done_flag, irq_n;
  logic [3:0] jack_status;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // Bench-side model of the expected route
  logic       e_three = 0, e_m1 = 0, e_g2 = 0, e_s2 = 0;
  logic [3:0] e_stat = 4'b0001;
  logic [7:0] cur_lo = 8'h20, cur_hi = 8'hFF;

  always #4 clk = ~clk;

  hs_orient_det #(.DLY_W(DLY_W)) dut_i (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_thr(input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk); thr_lo_wr = 1; thr_wdata = lo;
    @(negedge clk); thr_lo_wr = 0; thr_hi_wr = 1; thr_wdata = hi;
    @(negedge clk); thr_hi_wr = 0;
    cur_lo = lo; cur_hi = hi;
  endtask

  task automatic wait_sig(input bit want_l, input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (sw_l_on == want_l) return;
    end
  endtask

  // Independent restatement: largest/smallest of the pair
  task automatic model(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] mx, mn;
    mx = (a > b) ? a : b;
    mn = (a > b) ? b : a;
    if (mx <= cur_lo) begin
      e_three = 1; e_m1 = 0; e_g2 = 0; e_s2 = 0; e_stat = 4'b0010;
    end else if (mn >= cur_hi) begin
    end else if (a != b && mn < cur_hi) begin
      e_three = 0;
      e_m1 = (a > b); e_g2 = (a > b); e_s2 = (a > b);
      e_stat = (a > b) ? 4'b0100 : 4'b1000;
    end
  endtask

  task automatic run_det(input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk); det_arm = 1;
    @(negedge clk); det_arm = 0;
    wait_sig(1'b0, 20);
    chk({sw_l_on, sw_r_on, sw_mic_on, sw_sense_on, sw_gnd_on} == 5'b0, "R2 all off while deciding",
        {sw_l_on, sw_r_on, sw_mic_on, sw_sense_on, sw_gnd_on}, 0);
    meas_12 = a; meas_21 = b; meas_vld = 1;
    @(negedge clk); meas_vld = 0;
    for (int i = 0; i < 600; i++) begin
      if (!det_en_q) break;
      @(negedge clk);
    end
    model(a, b);
    chk(det_en_q == 0, "R3 enable self-clear", det_en_q, 0);
    chk({jack_status, mic_on_sbu1, gnd_on_sbu2, sense_on_gsbu2, sw_mic_on} ==
        {e_stat, e_m1, e_g2, e_s2, !e_three}, tag,
        {jack_status, mic_on_sbu1, gnd_on_sbu2, sense_on_gsbu2, sw_mic_on},
        {e_stat, e_m1, e_g2, e_s2, !e_three});
    chk(done_flag == 1 && irq_n == irq_mask, "R11 flag and irq on completion", {done_flag, irq_n}, {1'b1, irq_mask});
    irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk(done_flag == 0 && irq_n == 1, "R11 read-clear", {done_flag, irq_n}, 2'b01);
  endtask

  initial begin
    logic [7:0] vals [9] = '{8'h00, 8'h10, 8'h1F, 8'h20, 8'h21, 8'h80, 8'hF0, 8'hFE, 8'hFF};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(jack_status == 4'b0001, "R4 status reset", jack_status, 4'b0001);
    chk({det_en_q, done_flag, irq_n, mic_on_sbu1, gnd_on_sbu2, sense_on_gsbu2} == 6'b001000,
        "R4 control reset", {det_en_q, done_flag, irq_n, mic_on_sbu1, gnd_on_sbu2, sense_on_gsbu2}, 6'b001000);

    // R4 default thresholds: 0x20 pair is 3-pole only if the low threshold is 0x20
    run_det(8'h20, 8'h20, "R4 default low threshold");
    // 0xFF/0xFE both at or above 0xFF? no: R4 default high threshold -> 0xFE below, MIC SBU1
    run_det(8'hFF, 8'hFE, "R4 default high threshold");

    // R1: ground enable low blocks the start
    gnd_sw_en = 0;
    @(negedge clk); det_arm = 1;
    @(negedge clk); det_arm = 0;
    repeat (4) @(negedge clk);
    chk(sw_l_on == 1 && det_en_q == 1, "R1 start blocked", {sw_l_on, det_en_q}, 2'b11);
    gnd_sw_en = 1;
    repeat (2) @(negedge clk);
    chk(sw_l_on == 0, "R1 start after enables", sw_l_on, 0);
    meas_12 = 8'h10; meas_21 = 8'h80; meas_vld = 1;
    @(negedge clk); meas_vld = 0;
    repeat (4) @(negedge clk);
    model(8'h10, 8'h80);
    chk(jack_status == e_stat && jack_status == 4'b1000, "R7 mic on SBU2", jack_status, 4'b1000);
    irq_clr = 1; @(negedge clk); irq_clr = 0;

    // R12: staged release
    mic_dly = 3; sense_dly = 5; gnd_dly = 0;
    begin
      int k_mic, k_sns, k_gnd;
      k_mic = -1; k_sns = -1; k_gnd = -1;
      @(negedge clk); det_arm = 1;
      @(negedge clk); det_arm = 0;
      wait_sig(1'b0, 20);
      meas_12 = 8'h80; meas_21 = 8'h10; meas_vld = 1;
      @(negedge clk); meas_vld = 0;
      wait_sig(1'b1, 20);
      for (int k = 0; k < 10; k++) begin
        if (k_mic < 0 && sw_mic_on)   k_mic = k;
        if (k_sns < 0 && sw_sense_on) k_sns = k;
        if (k_gnd < 0 && sw_gnd_on)   k_gnd = k;
        @(negedge clk);
      end
      chk(k_mic == 3, "R12 mic release delay", k_mic, 3);
      chk(k_sns == 5, "R12 sense release delay", k_sns, 5);
      chk(k_gnd == 0, "R12 zero delay immediate", k_gnd, 0);
      model(8'h80, 8'h10);
      chk(jack_status == 4'b0100 && mic_on_sbu1, "R6 mic on SBU1", {jack_status, mic_on_sbu1}, 5'b01001);
      irq_clr = 1; @(negedge clk); irq_clr = 0;
    end
    mic_dly = 0; sense_dly = 0; gnd_dly = 0;

    // R11 mask
    irq_mask = 1;
    run_det(8'h05, 8'h06, "R5 three-pole masked run");
    irq_mask = 0;

    // R8: both high after 3-pole keeps the 3-pole route
    run_det(8'hFF, 8'hFF, "R8 both high holds");
    // R9: equal mid values hold
    run_det(8'h40, 8'h80, "R7 setup");
    run_det(8'h50, 8'h50, "R9 equal mid holds");

    // Sweep over two threshold settings
    for (int t = 0; t < 2; t++) begin
      if (t == 0) wr_thr(8'h20, 8'hFF);
      else        wr_thr(8'h40, 8'h90);
      for (int i = 0; i < 9; i++)
        for (int j = 0; j < 9; j++)
          run_det(vals[i], vals[j], "R5 R6 R7 R8 R9 R10 sweep route");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule